// File: doc/BRIEF.md
# Intra 16x16 DC Predictor Value Generator

This block produces the single DC prediction value used for a 16x16 luma block in an intra-prediction pipeline. A caller presents the reconstructed neighbours of the block as one flat vector and an availability mask, then pulses `start_i` for one cycle. The block captures both in that cycle. It then works through the two edges a few pixels at a time, summing only the edges the mask enables. It adds a rounding offset and shifts by an amount that depends on how many edges contributed, then saturates the result to eight bits.

The result appears on `dc_o` together with a one-cycle `done_o` pulse. It stays on `dc_o` until the next result replaces it. When no neighbour is available at all, the value is mid-grey. The `LANES` parameter sets how many rows of each edge are taken per cycle. With the default of 4, the whole sum takes four accumulation cycles.

Top module: `dcp_dc_gen`

## Requirements
- R1: After reset, `dc_o` reads 0 and `done_o` reads 0.
- R2: With mask bit 0 set and bit 2 clear, the value is (L + 8) >> 4. L is the sum of the 16 left pixels. Pixel k of the neighbour vector occupies `nbr_i[8k+7:8k]`, and the left pixels are k = 0..15, with k = 15 belonging to row 0.
- R3: With mask bit 2 set and bit 0 clear, the value is (T + 8) >> 4. T is the sum of the 16 top pixels at k = 17..32, left to right.
- R4: With mask bits 0 and 2 both set, the value is (L + T + 16) >> 5.
- R5: When the whole 3-bit mask is zero, the value is 128.
- R6: Mask bit 1 and the corner pixel at k = 16 never enter the sum. A mask of exactly 3'b010 therefore yields 0, because no edge is present and the shift is 3.
- R7: The pixels of an edge whose mask bit is clear contribute nothing, whatever their values.
- R8: The shifted result is clamped to 255, so all-255 neighbours give 255 for every mask that enables an edge.
- R9: `done_o` rises exactly STEPS+1 clock edges after the edge that accepts `start_i`, where STEPS = 16 / LANES. It stays high for exactly one cycle.
- R10: `dc_o` changes only in a cycle where `done_o` is high and holds its value otherwise.
- R11: A `start_i` that arrives while a computation is in progress is ignored. It produces neither a second result nor a change to the current one.
- R12: `nbr_i` and `avail_i` are sampled only at the accepting edge. Changing them afterwards does not alter the pending result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, accepted when idle |
| avail_i | input | 3 | Availability mask: bit 0 left edge, bit 2 top edge, bit 1 unused |
| nbr_i | input | 264 | 33 neighbour pixels, pixel k at bits [8k+7:8k] |
| dc_o | output | 8 | DC prediction value |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The hardest situation to reach is a second request landing while the first is still accumulating. It only appears when the caller breaks the expected one-request-at-a-time rhythm. The bench creates it on purpose: it holds `start_i` high into the first accumulation cycle, carrying different data and a zero mask. It then confirms that the one result which appears belongs to the first request and that no later pulse follows.

Stale-input leakage is reached in a similar way. After every accepted request, the bench inverts the neighbour vector and the mask on the pins, so any late sampling would corrupt the sum. The sweep covers every mask value against neighbour patterns that put extreme values on the disabled edge and on the corner.

// File: rtl/dcp_pkg.sv
// Package dcp_pkg
// Shared constants and the control state type of the DC value generator.
// Assumes the availability mask is three bits wide with the edges on bits 0 and 2.
package dcp_pkg;

    localparam int unsigned AVL_W    = 3;
    localparam int unsigned AVL_LEFT = 0;
    localparam int unsigned AVL_TOP  = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SUM  = 2'd1,
        ST_FIN  = 2'd2
    } dcp_state_e;

endpackage

// File: rtl/dcp_lane_pick.sv
// Module dcp_lane_pick
// Selects LANES rows of the left and top edges for one accumulation step and
// returns their masked sum. Left pixel of row r sits at index EDGE_PIX-1-r,
// top pixel of column r at index EDGE_PIX+1+r.
// Assumes step_i < EDGE_PIX/LANES; purely combinational.
module dcp_lane_pick #(
    parameter int unsigned PIX_W    = 8,
    parameter int unsigned EDGE_PIX = 16,
    parameter int unsigned LANES    = 4,
    parameter int unsigned STEP_W   = 2,
    parameter int unsigned ACC_W    = 14,
    localparam int unsigned NBR_N   = 2 * EDGE_PIX + 1
) (
    input  logic [NBR_N*PIX_W-1:0] nbr_q_i,
    input  logic [STEP_W-1:0]      step_i,
    input  logic                   use_left_i,
    input  logic                   use_top_i,
    output logic [ACC_W-1:0]       lane_sum_o
);

    logic [PIX_W-1:0] left_px [LANES];
    logic [PIX_W-1:0] top_px  [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Pick this lane's left and top pixel, forcing zero for a missing edge.
        always_comb begin
            int row;
            row = int'(step_i) * int'(LANES) + l;
            left_px[l] = use_left_i
                ? nbr_q_i[(int'(EDGE_PIX) - 1 - row) * int'(PIX_W) +: PIX_W]
                : '0;
            top_px[l]  = use_top_i
                ? nbr_q_i[(int'(EDGE_PIX) + 1 + row) * int'(PIX_W) +: PIX_W]
                : '0;
        end
    end

    // Reduce all lanes of both edges into one addend.
    always_comb begin
        lane_sum_o = '0;
        for (int l = 0; l < int'(LANES); l++) begin
            lane_sum_o = lane_sum_o + ACC_W'(left_px[l]) + ACC_W'(top_px[l]);
        end
    end

endmodule

// File: rtl/dcp_accum.sv
// Module dcp_accum
// Running sum of the edge pixels. A clear wins over an add.
// Assumes ACC_W is wide enough for 2*EDGE_PIX full-scale pixels.
module dcp_accum #(
    parameter int unsigned ACC_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             add_i,
    input  logic [ACC_W-1:0] addend_i,
    output logic [ACC_W-1:0] acc_o
);

    // Hold, clear or extend the running sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o <= '0;
        end else if (clear_i) begin
            acc_o <= '0;
        end else if (add_i) begin
            acc_o <= acc_o + addend_i;
        end
    end

endmodule

// File: rtl/dcp_round.sv
// Module dcp_round
// Turns the finished sum into the DC value. The offset is EDGE_PIX/2 per present
// edge, the shift is log2(EDGE_PIX)-1 plus one per present edge, and the result
// saturates to PIX_W bits. An all-zero mask gives mid-grey.
// Assumes EDGE_PIX is a power of two; purely combinational.
module dcp_round
    import dcp_pkg::*;
#(
    parameter int unsigned PIX_W    = 8,
    parameter int unsigned EDGE_PIX = 16,
    parameter int unsigned ACC_W    = 14
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [AVL_W-1:0] avail_i,
    output logic [PIX_W-1:0] dc_o
);

    localparam int unsigned SUM_W      = ACC_W + 1;
    localparam int unsigned SHIFT_BASE = $clog2(EDGE_PIX) - 1;
    localparam int unsigned RND_EDGE   = EDGE_PIX / 2;
    localparam logic [PIX_W-1:0] MID   = PIX_W'(1) << (PIX_W - 1);

    logic [1:0]       n_edges;
    logic [SUM_W-1:0] rounded;
    logic [SUM_W-1:0] shifted;

    // Count the edges that took part in the sum.
    always_comb begin
        n_edges = {1'b0, avail_i[AVL_LEFT]} + {1'b0, avail_i[AVL_TOP]};
    end

    // Add the rounding offset and apply the edge-dependent shift.
    always_comb begin
        rounded = {1'b0, acc_i} + SUM_W'(RND_EDGE) * SUM_W'(n_edges);
        shifted = rounded >> (SHIFT_BASE + int'(n_edges));
    end

    // Saturate, or fall back to mid-grey when the mask is empty.
    always_comb begin
        if (avail_i == '0) begin
            dc_o = MID;
        end else if (|shifted[SUM_W-1:PIX_W]) begin
            dc_o = '1;
        end else begin
            dc_o = shifted[PIX_W-1:0];
        end
    end

endmodule

// File: rtl/dcp_dc_gen.sv
// Module dcp_dc_gen (top)
// Captures the neighbour vector and mask on an accepted start, accumulates the
// enabled edges LANES rows per cycle, then registers the rounded DC value with a
// one-cycle done pulse. Starts are accepted only when idle, including the done cycle.
// Assumes LANES divides EDGE_PIX.
module dcp_dc_gen
    import dcp_pkg::*;
#(
    parameter int unsigned PIX_W    = 8,
    parameter int unsigned EDGE_PIX = 16,
    parameter int unsigned LANES    = 4,
    parameter int unsigned ACC_W    = 14,
    localparam int unsigned NBR_N   = 2 * EDGE_PIX + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [AVL_W-1:0]       avail_i,
    input  logic [NBR_N*PIX_W-1:0] nbr_i,
    output logic [PIX_W-1:0]       dc_o,
    output logic                   done_o
);

    localparam int unsigned STEPS  = EDGE_PIX / LANES;
    localparam int unsigned STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    dcp_state_e             state_q;
    logic [NBR_N*PIX_W-1:0] nbr_q;
    logic [AVL_W-1:0]       avail_q;
    logic [STEP_W-1:0]      step_q;
    logic                   accept;
    logic [ACC_W-1:0]       lane_sum;
    logic [ACC_W-1:0]       acc;
    logic [PIX_W-1:0]       dc_next;

    // A request is taken only while idle.
    always_comb begin
        accept = start_i && (state_q == ST_IDLE);
    end

    // Sequence idle -> accumulate -> finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_SUM;
                        step_q  <= '0;
                    end
                end
                ST_SUM: begin
                    step_q <= step_q + 1'b1;
                    if (step_q == LAST_STEP) begin
                        state_q <= ST_FIN;
                    end
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Snapshot the request inputs at the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nbr_q   <= '0;
            avail_q <= '0;
        end else if (accept) begin
            nbr_q   <= nbr_i;
            avail_q <= avail_i;
        end
    end

    dcp_lane_pick #(
        .PIX_W    (PIX_W),
        .EDGE_PIX (EDGE_PIX),
        .LANES    (LANES),
        .STEP_W   (STEP_W),
        .ACC_W    (ACC_W)
    ) u_pick (
        .nbr_q_i    (nbr_q),
        .step_i     (step_q),
        .use_left_i (avail_q[AVL_LEFT]),
        .use_top_i  (avail_q[AVL_TOP]),
        .lane_sum_o (lane_sum)
    );

    dcp_accum #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .add_i    (state_q == ST_SUM),
        .addend_i (lane_sum),
        .acc_o    (acc)
    );

    dcp_round #(
        .PIX_W    (PIX_W),
        .EDGE_PIX (EDGE_PIX),
        .ACC_W    (ACC_W)
    ) u_round (
        .acc_i   (acc),
        .avail_i (avail_q),
        .dc_o    (dc_next)
    );

    // Register the result and raise done for the finishing cycle only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dc_o   <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= (state_q == ST_FIN);
            if (state_q == ST_FIN) begin
                dc_o <= dc_next;
            end
        end
    end

endmodule

// File: rtl/dcp_dc_gen_chk.sv
// Module dcp_dc_gen_chk
// Port-level checker for dcp_dc_gen. Tracks accepted requests itself, counts
// cycles, and relates done_o and dc_o to the captured mask.
// Assumes starts are accepted when no request is pending or in the done cycle.
module dcp_dc_gen_chk #(
    parameter int unsigned PIX_W    = 8,
    parameter int unsigned EDGE_PIX = 16,
    parameter int unsigned LANES    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [2:0]       avail_i,
    input logic [PIX_W-1:0] dc_o,
    input logic             done_o
);

    localparam int unsigned STEPS = EDGE_PIX / LANES;

    logic       c_busy;
    logic [7:0] c_cnt;
    logic [2:0] c_avl;

    // Mirror the acceptance rule and count the edges since acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_busy <= 1'b0;
            c_cnt  <= '0;
            c_avl  <= '0;
        end else if (start_i && (!c_busy || done_o)) begin
            c_busy <= 1'b1;
            c_cnt  <= '0;
            c_avl  <= avail_i;
        end else if (done_o) begin
            c_busy <= 1'b0;
        end else if (c_busy && c_cnt != 8'hFF) begin
            c_cnt <= c_cnt + 8'd1;
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9 R11
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (c_busy && (int'(c_cnt) == int'(STEPS) + 1)));

    // R5
    mid_grey_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && c_avl == 3'b000) |-> (dc_o == PIX_W'(1) << (PIX_W - 1)));

    // R6
    corner_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && c_avl == 3'b010) |-> (dc_o == '0));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(dc_o));

endmodule

bind dcp_dc_gen dcp_dc_gen_chk #(
    .PIX_W    (PIX_W),
    .EDGE_PIX (EDGE_PIX),
    .LANES    (LANES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .avail_i (avail_i),
    .dc_o    (dc_o),
    .done_o  (done_o)
);

// File: tb/dcp_dc_gen_tb.sv
module dcp_dc_gen_tb;

    localparam int STEPS = 4;
    localparam int NW    = 33 * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [2:0]    avail_i = '0;
    logic [NW-1:0] nbr_i = '0;
    logic [7:0]    dc_o;
    logic          done_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] lfsr = 32'h1D2C_3B4A;

    always #4 clk = ~clk;

    dcp_dc_gen #(.PIX_W(8), .EDGE_PIX(16), .LANES(4), .ACC_W(14)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .avail_i (avail_i),
        .nbr_i   (nbr_i),
        .dc_o    (dc_o),
        .done_o  (done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_dc(input logic [2:0] av, input logic [NW-1:0] nb);
        int s = 0;
        int ne = 0;
        if (av == 3'b000) return 128;
        if (av[0]) begin
            ne++;
            for (int k = 0; k < 16; k++) s += int'(nb[8*k +: 8]);
        end
        if (av[2]) begin
            ne++;
            for (int k = 17; k < 33; k++) s += int'(nb[8*k +: 8]);
        end
        s = (s + 8 * ne) >> (3 + ne);
        if (s > 255) s = 255;
        return s;
    endfunction

    function automatic string req_of(input logic [2:0] av, input int p);
        if (av == 3'b000) return "R5";
        if (av == 3'b010) return "R6";
        if (p == 1) return "R8";
        if ((p == 4 || p == 5) && (av[0] != av[2])) return "R7";
        if (av[0] && av[2]) return "R4";
        if (av[0]) return "R2";
        return "R3";
    endfunction

    function automatic logic [31:0] step_lfsr(input logic [31:0] v);
        logic [31:0] x;
        x = v;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic make_pattern(input int p, output logic [NW-1:0] nb);
        for (int k = 0; k < 33; k++) begin
            logic [7:0] v;
            case (p)
                0: v = 8'd0;
                1: v = 8'd255;
                2: v = 8'(k * 7 + 3);
                4: v = (k < 16) ? 8'd255 : 8'd0;
                5: v = (k < 16) ? 8'd0 : 8'd255;
                6: v = k[0] ? 8'd255 : 8'd0;
                default: begin
                    lfsr = step_lfsr(lfsr);
                    v = lfsr[7:0];
                end
            endcase
            nb[8*k +: 8] = v;
        end
        if (p != 1) nb[8*16 +: 8] = 8'hC3;
    endtask

    // Issue one request, scramble the pins afterwards, and check timing and value.
    task automatic run_case(input logic [2:0] av, input logic [NW-1:0] nb, input string req);
        int exp;
        int n;
        logic [7:0] got;
        exp = exp_dc(av, nb);
        @(negedge clk);
        start_i = 1'b1;
        avail_i = av;
        nbr_i   = nb;
        n = 0;
        while (!done_o && n < 40) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                start_i = 1'b0;
                nbr_i   = ~nb;          // R12 late change must not leak
                avail_i = ~av;
            end
        end
        check(n == STEPS + 2, "R9 latency", n, STEPS + 2);
        got = dc_o;
        check(int'(got) == exp, req, int'(got), exp);
        @(negedge clk);
        check(done_o == 1'b0, "R9 pulse width", int'(done_o), 0);
        repeat (2) @(negedge clk);
        check(dc_o == got, "R10 hold", int'(dc_o), int'(got));
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NW-1:0] nb;
        logic [NW-1:0] nb2;
        int n;
        int exp;
        int dones;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(dc_o == 8'd0, "R1 dc", int'(dc_o), 0);
        check(done_o == 1'b0, "R1 done", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep every mask value over all patterns.
        for (int p = 0; p < 8; p++) begin
            for (int a = 0; a < 8; a++) begin
                make_pattern(p, nb);
                run_case(3'(a), nb, req_of(3'(a), p));
            end
        end

        // R11: second start while busy carries other data and a zero mask.
        make_pattern(3, nb);
        make_pattern(1, nb2);
        exp = exp_dc(3'b101, nb);
        @(negedge clk);
        start_i = 1'b1;
        avail_i = 3'b101;
        nbr_i   = nb;
        @(negedge clk);
        avail_i = 3'b000;
        nbr_i   = nb2;
        n = 1;
        @(negedge clk);
        start_i = 1'b0;
        n = 2;
        while (!done_o && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(n == STEPS + 2, "R11 latency", n, STEPS + 2);
        check(int'(dc_o) == exp, "R11 value", int'(dc_o), exp);
        dones = 0;
        repeat (12) begin
            @(negedge clk);
            if (done_o) dones++;
        end
        check(dones == 0, "R11 extra done", dones, 0);
        check(int'(dc_o) == exp, "R11 value kept", int'(dc_o), exp);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule